// File: doc/BRIEF.md
# Windowed Watchdog Timer with Early Warning

This block is a down-counting supervisor timer for a system-on-chip. Software programs a reload value, an upper feed window and a warning threshold through a small register write port. It then turns the timer on with a single control write. Once running, the timer cannot be switched off by software. Only a power-on reset or a system reset can stop it, and the system reset may be the one the watchdog itself requested.

To keep the timer from expiring, software feeds it with a two-step unlock: it writes one key to the feed register and then a second key. The feed is refused, and counted as a fault, if the second key is wrong or if the feed comes too early, while the count is still above the window value. An expired count and a feed fault are handled the same way. A control bit picks whether the fault produces a one-cycle reset request for the system reset controller or a sticky interrupt. In both cases a sticky fault flag is set, and that flag stays set across the system reset so that boot code can see why the system restarted. A separate sticky warning interrupt fires when the count passes a programmable threshold.

The write port is a plain register strobe and has no back-pressure: every write with `wr_en` high takes effect on that clock edge. No data stream enters or leaves the block. All outputs are registered.

Top module: `wwdt_core`

## Requirements
- R1: After any reset, the counter reads all ones and the timer is stopped. Writing 1 to control bit 0 (register 0) starts it. Writing 0 to that bit never stops it; only `por_n` or `sys_rst_n` low does.
- R2: While running, the count drops by one on every clock. On the edge where the count is zero, the count reloads from the reload register (register 1), the fault flag is set and the configured fault action is taken.
- R3: A feed is a write of 0x00AA to the feed register (register 2), then a feed-register write of 0x0055 as the next feed write, with any number of idle cycles between them. A good feed loads the reload value on the edge of the 0x0055 write. While the timer is stopped, feeds do not change the count.
- R4: Once 0x00AA has been written, a following feed write of any value other than 0x0055 is a fault while the timer runs. A feed write other than 0x00AA with no 0x00AA pending is ignored.
- R5: A completed key pair while the count is strictly above the window register (register 3, all ones after reset) is a fault, not a feed. At or below the window, the feed is good.
- R6: Control bit 1 selects the fault action, using its value at the fault: 1 gives a `rst_req_o` pulse in the cycle after the fault; 0 sets the sticky `evt_irq_o`. Every fault also reloads the count.
- R7: `tmo_flag_o` is set on every fault. It survives `sys_rst_n` and is cleared only by `por_n` low or by writing 1 to control bit 2, which also clears `evt_irq_o`. A set in the same cycle takes precedence over the clear.
- R8: While running, a count equal to the warning register (register 4, zero after reset) sets the sticky `warn_irq_o` on the next edge. Writing 1 to control bit 3 clears it.
- R9: `sys_rst_n` low returns every register, the count, the key state and both interrupts to their reset values, and leaves `tmo_flag_o` untouched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, synchronous, clears everything |
| sys_rst_n | input | 1 | System reset, active low, synchronous, keeps the fault flag |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select: 0 control, 1 reload, 2 feed, 3 window, 4 warning |
| wr_data | input | CW (16) | Write data |
| en_o | output | 1 | Timer running |
| cnt_o | output | CW (16) | Current count |
| rst_req_o | output | 1 | One-cycle reset request to the system reset controller |
| evt_irq_o | output | 1 | Sticky fault interrupt (interrupt mode) |
| warn_irq_o | output | 1 | Sticky warning interrupt |
| tmo_flag_o | output | 1 | Sticky fault flag, survives system reset |

## Verification
Assertions check on every cycle that the enable never drops outside reset and that a stopped timer keeps its count. They also check that an expired count is followed by the reload value, that the fault flag survives a system reset, and that a reset request or a fault interrupt always comes with the flag. The warning interrupt may rise only after the count has matched the threshold. The bench's scenarios are needed for the rest: whether a key pair is judged good or early against the window, whether a wrong second key is a fault while a stray idle write is not, and whether the write-1 clears beat or lose to a new event. They also show whether the mode bit sends a fault to the reset pulse or to the interrupt.

// File: rtl/wwdt_pkg.sv
package wwdt_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] ADDR_LOAD = 3'd1;
  localparam logic [ADDR_W-1:0] ADDR_FEED = 3'd2;
  localparam logic [ADDR_W-1:0] ADDR_WIN  = 3'd3;
  localparam logic [ADDR_W-1:0] ADDR_WARN = 3'd4;

  localparam int CTL_RUN      = 0;
  localparam int CTL_MODE_RST = 1;
  localparam int CTL_CLR_TMO  = 2;
  localparam int CTL_CLR_WARN = 3;
  localparam int CTL_W        = 4;

  localparam logic [7:0] KEY_ARM  = 8'hAA;
  localparam logic [7:0] KEY_FIRE = 8'h55;

  typedef enum logic {
    KEY_IDLE  = 1'b0,
    KEY_ARMED = 1'b1
  } key_state_e;
endpackage

// File: rtl/wwdt_cfg_regs.sv
module wwdt_cfg_regs
  import wwdt_pkg::*;
#(
  parameter int              CW       = 16,
  parameter logic [CW-1:0]   LOAD_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic              run,
  output logic              mode_rst,
  output logic [CW-1:0]     load_val,
  output logic [CW-1:0]     win_val,
  output logic [CW-1:0]     warn_val,
  output logic              clr_tmo,
  output logic              clr_warn,
  output logic              feed_wr
);
  logic ctrl_wr;
  logic ctrl_unused;

  assign ctrl_wr     = wr_en && (wr_addr == ADDR_CTRL);
  assign feed_wr     = wr_en && (wr_addr == ADDR_FEED);
  assign clr_tmo     = ctrl_wr && wr_data[CTL_CLR_TMO];
  assign clr_warn    = ctrl_wr && wr_data[CTL_CLR_WARN];
  assign ctrl_unused = ^wr_data[CW-1:CTL_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      mode_rst <= 1'b0;
      load_val <= LOAD_RST;
      win_val  <= '1;
      warn_val <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_CTRL: begin
          run      <= run | wr_data[CTL_RUN];
          mode_rst <= wr_data[CTL_MODE_RST];
        end
        ADDR_LOAD: load_val <= wr_data;
        ADDR_WIN:  win_val  <= wr_data;
        ADDR_WARN: warn_val <= wr_data;
        default: ;
      endcase
    end
  end

  // R1: once running, only a reset stops the timer
  assert_run_locked_R1: assert property (@(posedge clk) disable iff (rst)
    run |=> run);
endmodule

// File: rtl/wwdt_key_seq.sv
module wwdt_key_seq
  import wwdt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          feed_wr,
  input  logic [CW-1:0] feed_val,
  output logic          seq_ok,
  output logic          seq_err
);
  key_state_e state_q;
  key_state_e state_d;
  logic       is_arm;
  logic       is_fire;

  assign is_arm  = (feed_val == CW'(KEY_ARM));
  assign is_fire = (feed_val == CW'(KEY_FIRE));
  assign seq_ok  = feed_wr && (state_q == KEY_ARMED) && is_fire;
  assign seq_err = feed_wr && (state_q == KEY_ARMED) && !is_fire;

  always_comb begin
    state_d = state_q;
    if (feed_wr) begin
      state_d = (state_q == KEY_IDLE && is_arm) ? KEY_ARMED : KEY_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= KEY_IDLE;
    else     state_q <= state_d;
  end

  // R3: any feed write taken in the armed state closes the sequence
  assert_key_closes_R3: assert property (@(posedge clk) disable iff (rst)
    (seq_ok || seq_err) |=> state_q == KEY_IDLE);
endmodule

// File: rtl/wwdt_down_counter.sv
module wwdt_down_counter #(
  parameter int            CW       = 16,
  parameter logic [CW-1:0] LOAD_RST = '1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          reload,
  input  logic [CW-1:0] load_val,
  input  logic [CW-1:0] warn_val,
  output logic [CW-1:0] cnt,
  output logic          zero,
  output logic          warn_hit
);
  assign zero     = (cnt == '0);
  assign warn_hit = (cnt == warn_val);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= LOAD_RST;
    end else if (run) begin
      cnt <= reload ? load_val : cnt - 1'b1;
    end
  end

  // R3: a stopped timer keeps its count whatever is written
  assert_hold_when_off_R3: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(cnt));

  // R2: an expired count is followed by the reload value
  assert_expire_reload_R2: assert property (@(posedge clk) disable iff (rst)
    (run && zero) |=> cnt == $past(load_val));
endmodule

// File: rtl/wwdt_core.sv
module wwdt_core
  import wwdt_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              sys_rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic              en_o,
  output logic [CW-1:0]     cnt_o,
  output logic              rst_req_o,
  output logic              evt_irq_o,
  output logic              warn_irq_o,
  output logic              tmo_flag_o
);
  localparam logic [CW-1:0] LOAD_RST = '1;

  logic          rst;
  logic          run, mode_rst, clr_tmo, clr_warn, feed_wr;
  logic [CW-1:0] load_val, win_val, warn_val;
  logic          seq_ok, seq_err;
  logic          zero, warn_hit;
  logic          early, expire, fault, feed_good, reload;

  assign rst = !por_n || !sys_rst_n;

  wwdt_cfg_regs #(.CW(CW), .LOAD_RST(LOAD_RST)) u_regs (
    .clk, .rst, .wr_en, .wr_addr, .wr_data,
    .run, .mode_rst, .load_val, .win_val, .warn_val,
    .clr_tmo, .clr_warn, .feed_wr
  );

  wwdt_key_seq #(.CW(CW)) u_keys (
    .clk, .rst, .feed_wr, .feed_val(wr_data), .seq_ok, .seq_err
  );

  wwdt_down_counter #(.CW(CW), .LOAD_RST(LOAD_RST)) u_cnt (
    .clk, .rst, .run, .reload, .load_val, .warn_val,
    .cnt(cnt_o), .zero, .warn_hit
  );

  assign early     = run && seq_ok && (cnt_o > win_val);
  assign feed_good = run && seq_ok && !(cnt_o > win_val);
  assign expire    = run && zero;
  assign fault     = expire || early || (run && seq_err);
  assign reload    = fault || feed_good;
  assign en_o      = run;

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req_o  <= 1'b0;
      evt_irq_o  <= 1'b0;
      warn_irq_o <= 1'b0;
    end else begin
      rst_req_o <= fault && mode_rst;
      if (fault && !mode_rst) evt_irq_o <= 1'b1;
      else if (clr_tmo)       evt_irq_o <= 1'b0;
      if (run && warn_hit)    warn_irq_o <= 1'b1;
      else if (clr_warn)      warn_irq_o <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!por_n) begin
      tmo_flag_o <= 1'b0;
    end else if (sys_rst_n) begin
      if (fault)        tmo_flag_o <= 1'b1;
      else if (clr_tmo) tmo_flag_o <= 1'b0;
    end
  end

  // R7: a system reset alone never clears the fault flag
  assert_flag_survives_R7: assert property (@(posedge clk) disable iff (!por_n)
    (!sys_rst_n && tmo_flag_o) |=> tmo_flag_o);

  // R6: a reset request always comes with the fault flag
  assert_req_has_flag_R6: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> tmo_flag_o);

  // R6: a rising fault interrupt always comes with the fault flag
  assert_irq_has_flag_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(evt_irq_o) |-> tmo_flag_o);

  // R8: the warning rises only after the count matched the threshold
  assert_warn_cause_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(warn_irq_o) |-> $past(cnt_o) == $past(warn_val));
endmodule

// File: tb/wwdt_core_tb_top.sv
module wwdt_core_tb_top;
  localparam int CW = 16;
  localparam logic [2:0] A_CTRL = 3'd0, A_LOAD = 3'd1, A_FEED = 3'd2,
                         A_WIN = 3'd3, A_WARN = 3'd4;

  logic          clk = 1'b0;
  logic          por_n, sys_rst_n, wr_en;
  logic [2:0]    wr_addr;
  logic [CW-1:0] wr_data;
  logic          en_o, rst_req_o, evt_irq_o, warn_irq_o, tmo_flag_o;
  logic [CW-1:0] cnt_o;

  int checks = 0;
  int fails  = 0;
  bit chk_on = 1'b0;

  always #10 clk = ~clk;

  wwdt_core #(.CW(CW)) dut_i (
    .clk, .por_n, .sys_rst_n, .wr_en, .wr_addr, .wr_data,
    .en_o, .cnt_o, .rst_req_o, .evt_irq_o, .warn_irq_o, .tmo_flag_o
  );

  // expected state, built from the requirements
  logic          m_run, m_mode, m_armed, m_tflag, m_eirq, m_wirq, m_rreq;
  logic [CW-1:0] m_load, m_win, m_warn, m_cnt;

  function automatic logic key_ok(logic armed, logic [CW-1:0] d);
    return armed && d == 16'h0055;
  endfunction

  task automatic model_step();
    logic fw, ok, bad, flt, good;
    if (!por_n || !sys_rst_n) begin
      m_run = 0; m_mode = 0; m_armed = 0; m_eirq = 0; m_wirq = 0; m_rreq = 0;
      m_load = '1; m_win = '1; m_warn = '0; m_cnt = '1;
      if (!por_n) m_tflag = 0;
      return;
    end
    fw   = wr_en && wr_addr == A_FEED;
    ok   = fw && key_ok(m_armed, wr_data);
    bad  = fw && m_armed && !ok;
    flt  = m_run && ((m_cnt == 0) || bad || (ok && m_cnt > m_win));
    good = m_run && ok && !(m_cnt > m_win);
    m_rreq = flt && m_mode;
    if (flt && !m_mode) m_eirq = 1;
    else if (wr_en && wr_addr == A_CTRL && wr_data[2]) m_eirq = 0;
    if (flt) m_tflag = 1;
    else if (wr_en && wr_addr == A_CTRL && wr_data[2]) m_tflag = 0;
    if (m_run && m_cnt == m_warn) m_wirq = 1;
    else if (wr_en && wr_addr == A_CTRL && wr_data[3]) m_wirq = 0;
    if (m_run) m_cnt = (flt || good) ? m_load : m_cnt - 1'b1;
    if (fw) m_armed = !m_armed && wr_data == 16'h00AA;
    if (wr_en) begin
      case (wr_addr)
        A_CTRL: begin m_run = m_run | wr_data[0]; m_mode = wr_data[1]; end
        A_LOAD: m_load = wr_data;
        A_WIN:  m_win  = wr_data;
        A_WARN: m_warn = wr_data;
        default: ;
      endcase
    end
  endtask

  always @(posedge clk) model_step();

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      chk("R1 run",        32'(en_o),       32'(m_run));
      chk("R2 count",      32'(cnt_o),      32'(m_cnt));
      chk("R6 reset req",  32'(rst_req_o),  32'(m_rreq));
      chk("R6 fault irq",  32'(evt_irq_o),  32'(m_eirq));
      chk("R7 fault flag", 32'(tmo_flag_o), 32'(m_tflag));
      chk("R8 warning",    32'(warn_irq_o), 32'(m_wirq));
    end
  end

  task automatic wr(input logic [2:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic pulse_sys();
    @(negedge clk); sys_rst_n = 0;
    @(negedge clk); sys_rst_n = 1;
  endtask

  task automatic pulse_por();
    @(negedge clk); por_n = 0;
    @(negedge clk); por_n = 1;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired: actual=running expected=done");
    finish_run();
  end

  initial begin
    int unsigned r;
    bit pend;
    r = $urandom(32'h5EED1);
    por_n = 0; sys_rst_n = 0; wr_en = 0; wr_addr = '0; wr_data = '0;
    repeat (3) @(negedge clk);
    por_n = 1; sys_rst_n = 1;
    chk_on = 1;

    // R1 R9: reset state
    chk("R1 reset count", 32'(cnt_o), 32'hFFFF);
    chk("R1 reset run", 32'(en_o), 0);
    chk("R9 reset flag", 32'(tmo_flag_o), 0);

    // R3: feeds while stopped leave the count alone
    wr(A_LOAD, 16'd40);
    wr(A_FEED, 16'h00AA); wr(A_FEED, 16'h0055);
    chk("R3 stopped feed", 32'(cnt_o), 32'hFFFF);

    // R1: start, then a zero write does not stop
    wr(A_CTRL, 16'h0001);
    wr(A_CTRL, 16'h0000);
    chk("R1 lock", 32'(en_o), 1);

    // R3 R2: good feed reloads, then counts down
    wr(A_FEED, 16'h00AA); wr(A_FEED, 16'h0055);
    chk("R3 reload", 32'(cnt_o), 40);
    repeat (5) @(negedge clk);
    chk("R2 decrement", 32'(cnt_o), 35);

    // R5 R6: early feed is a fault, interrupt mode
    wr(A_WIN, 16'd10);
    wr(A_FEED, 16'h00AA); wr(A_FEED, 16'h0055);
    chk("R5 early fault", 32'(tmo_flag_o), 1);
    chk("R6 irq mode", 32'(evt_irq_o), 1);
    chk("R6 fault reload", 32'(cnt_o), 40);
    wr(A_CTRL, 16'h0005);
    chk("R7 clear flag", 32'(tmo_flag_o), 0);
    chk("R7 clear irq", 32'(evt_irq_o), 0);

    // R4: stray write ignored, wrong second key is a fault
    wr(A_FEED, 16'h0012);
    chk("R4 idle write", 32'(tmo_flag_o), 0);
    wr(A_FEED, 16'h00AA); wr(A_FEED, 16'h00AB);
    chk("R4 bad key", 32'(tmo_flag_o), 1);
    wr(A_CTRL, 16'h0005);

    // R5: feed inside the window is good
    while (cnt_o > 8) @(negedge clk);
    wr(A_FEED, 16'h00AA); wr(A_FEED, 16'h0055);
    chk("R5 window feed", 32'(cnt_o), 40);
    chk("R5 no fault", 32'(tmo_flag_o), 0);

    // R8: warning at threshold
    wr(A_WARN, 16'd30);
    while (cnt_o != 30) @(negedge clk);
    chk("R8 before hit", 32'(warn_irq_o), 0);
    @(negedge clk);
    chk("R8 after hit", 32'(warn_irq_o), 1);
    wr(A_CTRL, 16'h0009);
    chk("R8 clear", 32'(warn_irq_o), 0);

    // R6 R2 R7 R9: reset mode, expiry, system reset, power-on reset
    wr(A_CTRL, 16'h0003);
    for (int k = 0; k < 200 && !rst_req_o; k++) @(negedge clk);
    chk("R6 reset pulse", 32'(rst_req_o), 1);
    chk("R2 expiry reload", 32'(cnt_o), 40);
    chk("R6 no irq", 32'(evt_irq_o), 0);
    @(negedge clk);
    chk("R6 one cycle", 32'(rst_req_o), 0);
    pulse_sys();
    chk("R9 run cleared", 32'(en_o), 0);
    chk("R9 count reset", 32'(cnt_o), 32'hFFFF);
    chk("R7 flag kept", 32'(tmo_flag_o), 1);
    pulse_por();
    chk("R7 por clears", 32'(tmo_flag_o), 0);

    // constrained random traffic against the expected state
    pend = 0;
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk);
      wr_en = 0; sys_rst_n = 1; por_n = 1;
      r = $urandom_range(0, 999);
      if (rst_req_o || r < 3) sys_rst_n = 0;
      else if (r < 4) por_n = 0;
      else if (pend) begin
        wr_en = 1; wr_addr = A_FEED;
        wr_data = ($urandom_range(0, 7) == 0) ? 16'h0057 : 16'h0055;
        pend = 0;
      end else begin
        r = $urandom_range(0, 99);
        wr_data = '0;
        if (r < 55) wr_en = 0;
        else if (r < 67) begin wr_en = 1; wr_addr = A_FEED; wr_data = 16'h00AA; pend = 1; end
        else if (r < 71) begin wr_en = 1; wr_addr = A_FEED; wr_data = 16'($urandom_range(0, 255)); end
        else if (r < 78) begin
          wr_en = 1; wr_addr = A_CTRL;
          wr_data = {12'h0, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
                     1'($urandom_range(0, 1)), 1'($urandom_range(0, 5) != 0)};
        end
        else if (r < 84) begin wr_en = 1; wr_addr = A_LOAD; wr_data = 16'($urandom_range(6, 70)); end
        else if (r < 90) begin
          wr_en = 1; wr_addr = A_WIN;
          wr_data = ($urandom_range(0, 3) == 0) ? 16'hFFFF : 16'($urandom_range(0, 70));
        end
        else if (r < 95) begin wr_en = 1; wr_addr = A_WARN; wr_data = 16'($urandom_range(0, 70)); end
        else begin wr_en = 1; wr_addr = A_FEED; wr_data = 16'h0055; end
      end
    end
    @(negedge clk);
    wr_en = 0; sys_rst_n = 1; por_n = 1;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule